// File: doc/BRIEF.md
# NRZI Serial Symbol Receiver

This block turns an NRZI bit stream, already sampled on a recovered bit clock, into 5-bit parallel symbols. Each bit-clock cycle it picks one serial source, decodes the transition-coded bit to NRZ, and shifts the result into a five-stage register. It also divides the bit clock by five to make a symbol clock that is high for two bit times and low for three. The parallel word is loaded from the shifter at each falling edge of that symbol clock. The receiver does not align symbols, so a word boundary has no fixed relation to code-group boundaries.

An active-low loopback select picks the local loopback input instead of the line input. A signal-detect input qualifies the line: while it is low and loopback is not selected, the line data is treated as zero and the parallel word is held at all zeros. Loopback overrides signal detect. A copy of signal detect, sampled on the rising edge of a separate local symbol clock, is output with the same polarity.

The symbol-clock divider is a two-state machine. `PH_HIGH` drives the symbol clock high and `PH_LOW` drives it low. A phase counter runs 0 to 4 across both states. The transition `PH_HIGH -> PH_LOW` is taken when the counter is 1; this is the load edge. The transition `PH_LOW -> PH_HIGH` is taken when the counter is 4, and the counter then wraps to 0. Reset puts the machine in `PH_HIGH` with the counter at 0.

Top module: `nrzi_sym_rx`

## Requirements
- R1: While `loop_sel_n` is 0, `loop_in` is the decoded source and `sig_det_in` has no effect on `sym_word_o`.
- R2: While `loop_sel_n` is 1 and `sig_det_in` is 1, `line_in` is the decoded source.
- R3: At every bit-clock edge where `loop_sel_n` is 1 and `sig_det_in` is 0, the line sample is taken as 0 and `sym_word_o` becomes all zeros.
- R4: Each decoded NRZ bit is the XOR of the current selected sample and the previous selected sample; the previous sample is 0 after reset.
- R5: `sym_clk_o` repeats a pattern of 2 bit-clock cycles high followed by 3 cycles low; it is high during reset and for the first two cycles after reset.
- R6: `sym_word_o` changes only at the bit-clock edge where `sym_clk_o` falls, or at an edge where R3 clears it.
- R7: At a load edge, `sym_word_o` takes the NRZ bits decoded at that edge and the four edges before it; the earliest bit goes to bit 4 and the newest to bit 0.
- R8: `sig_det_o` equals `sig_det_in` sampled at the latest rising edge of `clk_loc`, with the same polarity.
- R9: Synchronous reset `rst` clears the divider phase, the previous-sample register, the shifter and the output word on `clk_bit`, and clears `sig_det_o` on `clk_loc`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bit | input | 1 | Recovered bit clock |
| clk_loc | input | 1 | Local symbol-rate clock used to sample signal detect |
| rst | input | 1 | Synchronous reset, active high, seen by both clocks |
| line_in | input | 1 | NRZI sample from the line |
| loop_in | input | 1 | NRZI sample from the local loopback path |
| loop_sel_n | input | 1 | Loopback select, active low |
| sig_det_in | input | 1 | Line signal detect, active high |
| sym_word_o | output | SYM_BITS | Unframed parallel symbol |
| sym_clk_o | output | 1 | Symbol clock: bit clock divided by five, 2 high / 3 low |
| sig_det_o | output | 1 | Signal detect sampled on `clk_loc` |

## Verification
The bench checks the load edge exactly. If the word were loaded one edge early or late, or taken from the shifter before the current bit enters it, every word would shift by one bit against the reference queue. It toggles signal detect in the middle of a symbol, so a design that gated only at the load edge, or that cleared the word without gating the line sample, would show stale words or a wrong first bit after detect returns. In loopback it holds signal detect low, where a design that let detect override loopback would output zeros. Constant-one and alternating NRZI patterns expose a decoder that uses a wrong previous value or a nonzero reset value.

// File: rtl/nrzi_rx_pkg.sv
package nrzi_rx_pkg;

    // Symbol clock phase of the divide-by-five machine.
    typedef enum logic {
        PH_HIGH = 1'b0,
        PH_LOW  = 1'b1
    } sclk_phase_e;

endpackage

// File: rtl/nrzi_symclk_fsm.sv
module nrzi_symclk_fsm
    import nrzi_rx_pkg::*;
#(
    parameter int SYM_BITS  = 5,
    parameter int HIGH_BITS = 2
) (
    input  logic clk,
    input  logic rst,
    output logic sym_clk_o,
    output logic load_o
);
    localparam int CNT_W = (SYM_BITS > 1) ? $clog2(SYM_BITS) : 1;
    localparam logic [CNT_W-1:0] LAST_HI = CNT_W'(HIGH_BITS - 1);
    localparam logic [CNT_W-1:0] LAST_CT = CNT_W'(SYM_BITS - 1);

    sclk_phase_e      state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // State register.
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PH_HIGH;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Next state and phase count.
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q + CNT_W'(1);
        unique case (state_q)
            PH_HIGH: begin
                if (cnt_q == LAST_HI) state_d = PH_LOW;
            end
            PH_LOW: begin
                if (cnt_q == LAST_CT) begin
                    state_d = PH_HIGH;
                    cnt_d   = '0;
                end
            end
            default: begin
                state_d = PH_HIGH;
                cnt_d   = '0;
            end
        endcase
    end

    // Outputs.
    always_comb begin
        sym_clk_o = 1'b0;
        load_o    = 1'b0;
        unique case (state_q)
            PH_HIGH: begin
                sym_clk_o = 1'b1;
                load_o    = (cnt_q == LAST_HI);
            end
            PH_LOW: begin
                sym_clk_o = 1'b0;
            end
            default: begin
                sym_clk_o = 1'b0;
            end
        endcase
    end

    assert_cnt_range_R5: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LAST_CT);

    assert_low_after_high_R5: assert property (@(posedge clk) disable iff (rst)
        (state_q == PH_LOW) |-> (cnt_q > LAST_HI));

endmodule

// File: rtl/nrzi_front.sv
module nrzi_front (
    input  logic clk,
    input  logic rst,
    input  logic line_in,
    input  logic loop_in,
    input  logic loop_sel_n,
    input  logic sig_det_in,
    output logic nrz_o,
    output logic clear_o
);
    logic gated;
    logic sel_bit;
    logic prev_q;

    // Loopback wins over signal detect; gating applies to the line only.
    always_comb begin
        gated   = loop_sel_n & ~sig_det_in;
        sel_bit = loop_sel_n ? (line_in & ~gated) : loop_in;
        nrz_o   = sel_bit ^ prev_q;
        clear_o = gated;
    end

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= sel_bit;
    end

    assert_loop_path_R1: assert property (@(posedge clk) disable iff (rst)
        !loop_sel_n |=> (prev_q == $past(loop_in)));

    assert_line_gated_R3: assert property (@(posedge clk) disable iff (rst)
        (loop_sel_n && !sig_det_in) |=> !prev_q);

    assert_line_path_R2: assert property (@(posedge clk) disable iff (rst)
        (loop_sel_n && sig_det_in) |=> (prev_q == $past(line_in)));

endmodule

// File: rtl/nrzi_sym_deser.sv
module nrzi_sym_deser #(
    parameter int SYM_BITS = 5
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bit_i,
    input  logic                load_i,
    input  logic                clear_i,
    output logic [SYM_BITS-1:0] word_o
);
    logic [SYM_BITS-1:0] shift_q;
    logic [SYM_BITS-1:0] shift_d;
    logic [SYM_BITS-1:0] word_q;

    // Newest bit enters at bit 0, so the oldest ends up at the top.
    always_comb shift_d = {shift_q[SYM_BITS-2:0], bit_i};

    always_ff @(posedge clk) begin
        if (rst) begin
            shift_q <= '0;
            word_q  <= '0;
        end else begin
            shift_q <= shift_d;
            if (clear_i)     word_q <= '0;
            else if (load_i) word_q <= shift_d;
        end
    end

    assign word_o = word_q;

    assert_word_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (!load_i && !clear_i) |=> $stable(word_q));

    assert_newest_bit_R7: assert property (@(posedge clk) disable iff (rst)
        (load_i && !clear_i) |=> (word_q[0] == $past(bit_i)));

endmodule

// File: rtl/nrzi_sd_sync.sv
module nrzi_sd_sync (
    input  logic clk,
    input  logic rst,
    input  logic sd_i,
    output logic sd_o
);
    logic sd_q;

    always_ff @(posedge clk) begin
        if (rst) sd_q <= 1'b0;
        else     sd_q <= sd_i;
    end

    assign sd_o = sd_q;

    assert_sd_copy_R8: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (sd_o == $past(sd_i)));

endmodule

// File: rtl/nrzi_sym_rx.sv
module nrzi_sym_rx #(
    parameter int SYM_BITS  = 5,
    parameter int HIGH_BITS = 2
) (
    input  logic                clk_bit,
    input  logic                clk_loc,
    input  logic                rst,
    input  logic                line_in,
    input  logic                loop_in,
    input  logic                loop_sel_n,
    input  logic                sig_det_in,
    output logic [SYM_BITS-1:0] sym_word_o,
    output logic                sym_clk_o,
    output logic                sig_det_o
);
    logic nrz_bit;
    logic clear_w;
    logic load_w;

    nrzi_symclk_fsm #(
        .SYM_BITS (SYM_BITS),
        .HIGH_BITS(HIGH_BITS)
    ) u_fsm (
        .clk      (clk_bit),
        .rst      (rst),
        .sym_clk_o(sym_clk_o),
        .load_o   (load_w)
    );

    nrzi_front u_front (
        .clk       (clk_bit),
        .rst       (rst),
        .line_in   (line_in),
        .loop_in   (loop_in),
        .loop_sel_n(loop_sel_n),
        .sig_det_in(sig_det_in),
        .nrz_o     (nrz_bit),
        .clear_o   (clear_w)
    );

    nrzi_sym_deser #(
        .SYM_BITS(SYM_BITS)
    ) u_deser (
        .clk    (clk_bit),
        .rst    (rst),
        .bit_i  (nrz_bit),
        .load_i (load_w),
        .clear_i(clear_w),
        .word_o (sym_word_o)
    );

    nrzi_sd_sync u_sd (
        .clk (clk_loc),
        .rst (rst),
        .sd_i(sig_det_in),
        .sd_o(sig_det_o)
    );

    assert_gate_zero_R3: assert property (@(posedge clk_bit) disable iff (rst)
        (loop_sel_n && !sig_det_in) |=> (sym_word_o == '0));

    assert_load_while_high_R6: assert property (@(posedge clk_bit) disable iff (rst)
        load_w |-> sym_clk_o);

    assert_fall_after_load_R6: assert property (@(posedge clk_bit) disable iff (rst)
        load_w |=> !sym_clk_o);

    assert_rise_after_low_R5: assert property (@(posedge clk_bit) disable iff (rst)
        $rose(sym_clk_o) |=> sym_clk_o);

endmodule

// File: tb/nrzi_sym_rx_test.sv
module nrzi_sym_rx_test;
    localparam int BIT_PERIOD = 8;
    localparam int W  = 5;
    localparam int HI = 2;

    logic clk_bit = 1'b0;
    logic clk_loc = 1'b0;
    logic rst = 1'b1;
    logic line_in = 1'b0, loop_in = 1'b0, loop_sel_n = 1'b1, sig_det_in = 1'b0;
    logic [W-1:0] sym_word_o;
    logic sym_clk_o, sig_det_o;

    int n_checks = 0;
    int n_fails  = 0;
    bit done = 0;
    string cur_req = "R9";

    nrzi_sym_rx #(.SYM_BITS(W), .HIGH_BITS(HI)) uut (
        .clk_bit(clk_bit), .clk_loc(clk_loc), .rst(rst),
        .line_in(line_in), .loop_in(loop_in), .loop_sel_n(loop_sel_n),
        .sig_det_in(sig_det_in), .sym_word_o(sym_word_o),
        .sym_clk_o(sym_clk_o), .sig_det_o(sig_det_o));

    always #(BIT_PERIOD/2) clk_bit = ~clk_bit;
    initial begin
        #2;
        forever #(BIT_PERIOD*W/2) clk_loc = ~clk_loc;
    end

    // Behavioural reference model.
    bit mq[$];
    int ph = 0;
    bit prv = 0;
    logic [W-1:0] ew = '0;
    bit m_load = 0, m_clear = 0, m_rst = 1;
    logic exp_sd = 1'b0;

    always @(posedge clk_bit) begin
        m_rst = rst;
        m_load = 0;
        m_clear = 0;
        if (rst) begin
            ph = 0; prv = 0; ew = '0;
            mq.delete();
            for (int i = 0; i < W; i++) mq.push_back(1'b0);
        end else begin
            bit s, d;
            s = loop_sel_n ? (sig_det_in & line_in) : loop_in;
            d = s ^ prv;
            prv = s;
            mq.push_back(d);
            void'(mq.pop_front());
            if (loop_sel_n && !sig_det_in) begin
                ew = '0; m_clear = 1;
            end else if (ph == HI-1) begin
                for (int i = 0; i < W; i++) ew[W-1-i] = mq[i];
                m_load = 1;
            end
            ph = (ph + 1) % W;
        end
    end

    always @(posedge clk_loc) begin
        if (rst) exp_sd = 1'b0;
        else     exp_sd = sig_det_in;
    end

    task automatic check(string req, string what, logic [W-1:0] act, logic [W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk_bit) begin
        if (!done) begin
            string lbl;
            check(m_rst ? "R9" : "R5", "sym_clk_o", {{(W-1){1'b0}}, sym_clk_o},
                  {{(W-1){1'b0}}, (ph < HI)});
            if (m_rst)        lbl = "R9";
            else if (m_clear) lbl = "R3";
            else if (m_load)  lbl = cur_req;
            else              lbl = "R6";
            check(lbl, "sym_word_o", sym_word_o, ew);
        end
    end

    always @(negedge clk_loc) begin
        if (!done) check("R8", "sig_det_o", {{(W-1){1'b0}}, sig_det_o},
                         {{(W-1){1'b0}}, exp_sd});
    end

    logic [15:0] lfsr = 16'hACE1;

    // pat: 0 pseudo-random, 1 constant one, 2 alternating; sd_tog toggles detect.
    task automatic run(int n, int pat, int sd_tog);
        for (int i = 0; i < n; i++) begin
            @(negedge clk_bit);
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            case (pat)
                0: begin line_in = lfsr[0]; loop_in = lfsr[5]; end
                1: begin line_in = 1'b1;    loop_in = 1'b1;    end
                default: begin line_in = i[0]; loop_in = ~i[0]; end
            endcase
            if (sd_tog != 0 && (i % sd_tog) == sd_tog - 1) sig_det_in = ~sig_det_in;
        end
    endtask

    initial begin
        repeat (12) @(negedge clk_bit);
        rst = 1'b0;
        // R2 / R7: line path with detect high.
        cur_req = "R7";
        loop_sel_n = 1'b1; sig_det_in = 1'b1;
        run(200, 0, 0);
        // R4: constant-one and alternating NRZI.
        cur_req = "R4";
        run(40, 1, 0);
        run(40, 2, 0);
        run(30, 0, 0);
        // R3: detect toggles mid-symbol while on the line.
        cur_req = "R2";
        run(200, 0, 7);
        // R1: loopback with detect low, then high.
        cur_req = "R1";
        loop_sel_n = 1'b0; sig_det_in = 1'b0;
        run(120, 0, 0);
        run(40, 2, 0);
        sig_det_in = 1'b1;
        run(60, 0, 11);
        // R9: reset in the middle of traffic.
        @(negedge clk_bit); rst = 1'b1;
        run(12, 0, 0);
        @(negedge clk_bit); rst = 1'b0;
        cur_req = "R7";
        loop_sel_n = 1'b1; sig_det_in = 1'b1;
        run(100, 0, 0);
        repeat (12) @(negedge clk_bit);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    initial begin
        #(BIT_PERIOD * 200000);
        done = 1;
        n_checks++;
        n_fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

endmodule